// File: doc/BRIEF.md
# Cycle-stealing memory refresh address generator

This block keeps a 512-word dynamic data memory alive by borrowing memory cycles that the running program does not need. It sits next to the instruction decoder. It looks at one bit of each instruction's destination-register field. When that bit shows that the instruction cannot write the memory address or data registers, the block claims the cycle for a refresh. A refresh is a read of one word followed by a write-back at the same address. The block raises a refresh request and a select for the extra address multiplexer, and it drives the address of the word to refresh.

The refresh addresses come from a linear feedback shift register whose feedback is a single two-input XOR. With the default 9-bit register, the sequence covers every nonzero address once in each run of 511 refreshes. Address 0 is never refreshed; that word holds the program counter, which is rewritten all the time. A wider 11-bit variant is also available, and its low 9 bits form the address. The register moves forward only when a refresh is actually issued.

A program may run many instructions in a row that all target memory registers. To keep the memory from going unrefreshed, a starvation counter counts these instructions. Once the count reaches a limit (8 by default), the next cycle with no valid instruction is taken as a forced refresh. Idle cycles are not used for refresh at any other time.

Top module: `dram_refresh_steal`

## Requirements
- R1: After reset, refresh_req and addr_sel are 0 and refresh_addr is 1, the nonzero seed.
- R2: In a cycle with instr_valid=1 and dest_field MSB=0, refresh_req and addr_sel are both 1 in that same cycle. Each lasts only for the cycles that qualify.
- R3: In a cycle with instr_valid=1 and dest_field MSB=1 (a memory address/data register is the destination), refresh_req and addr_sel are 0.
- R4: After each cycle with refresh_req=1, refresh_addr becomes {a[7:0], a[8]^a[4]}, where a is the address that was just refreshed.
- R5: After a cycle with refresh_req=0, refresh_addr does not change.
- R6: Starting from reset, 511 refreshes in a row produce 511 distinct nonzero addresses. The 512th refresh repeats the first address.
- R7: Suppose 8 (STARVE_LIMIT) valid instructions with dest MSB=1 have arrived since the last refresh. Then the next cycle with instr_valid=0 issues a forced refresh.
- R8: A cycle with instr_valid=0 issues no refresh while the starvation count is below the limit. Idle cycles do not add to the count, and any refresh clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction occupies this cycle |
| dest_field | input | DEST_W | Destination-register field of that instruction; MSB=1 means a memory register |
| refresh_req | output | 1 | This cycle is a refresh read-and-rewrite |
| refresh_addr | output | ADDR_W | Word to refresh |
| addr_sel | output | 1 | Selects refresh_addr onto the memory address bus |

## Verification
The forced refresh is the hardest case to reach. It needs an unbroken run of memory-register instructions that reaches the limit, and then an idle cycle. The stimulus table builds that run with idle cycles placed inside it, so that it shows idle cycles neither count nor refresh while the count is low. It then sends a memory-register instruction past the limit before the idle slot arrives. The full-period walk issues 511 eligible instructions and keeps a record of every address seen, so it can catch any repeat or a zero address.

// File: rtl/dram_refresh_steal.sv
module dram_refresh_steal #(
  parameter int ADDR_W       = 9,
  parameter int DEST_W       = 4,
  parameter bit WIDE_LFSR    = 1'b0,
  parameter int STARVE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [DEST_W-1:0] dest_field,
  output logic              refresh_req,
  output logic [ADDR_W-1:0] refresh_addr,
  output logic              addr_sel
);
  localparam int LW     = WIDE_LFSR ? ADDR_W + 2 : ADDR_W;
  localparam int TAP_LO = WIDE_LFSR ? 9 : 5;
  localparam int CW     = $clog2(STARVE_LIMIT + 1);
  localparam logic [CW-1:0] LIM  = CW'(STARVE_LIMIT);
  localparam logic [LW-1:0] SEED = LW'(1);

  logic [LW-1:0] lfsr;
  logic [CW-1:0] starve_cnt;
  logic          mem_dest, starving, issue;

  assign mem_dest = dest_field[DEST_W-1];
  assign starving = (starve_cnt >= LIM);
  assign issue    = instr_valid ? !mem_dest : starving;

  assign refresh_req  = issue;
  assign addr_sel     = issue;
  assign refresh_addr = lfsr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= SEED;
    end else if (issue) begin
      lfsr <= {lfsr[LW-2:0], lfsr[LW-1] ^ lfsr[TAP_LO-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      starve_cnt <= '0;
    end else if (issue) begin
      starve_cnt <= '0;
    end else if (instr_valid && mem_dest && !starving) begin
      starve_cnt <= starve_cnt + 1'b1;
    end
  end

  assert_no_mem_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && mem_dest) |-> !refresh_req);

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> (refresh_addr != $past(refresh_addr)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_req |=> $stable(refresh_addr));

  assert_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && starve_cnt < LIM) |-> !refresh_req);

  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> (starve_cnt == '0));
endmodule

// File: tb/sim_dram_refresh_steal.sv
`timescale 1ns/100ps
module sim_dram_refresh_steal;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [3:0] dest_field = 4'b0;
  logic refresh_req, addr_sel;
  logic [8:0] refresh_addr;

  int checks = 0;
  int errors = 0;
  logic [8:0] model_addr;
  logic seen [512];

  always #2.5 clk = ~clk;

  dram_refresh_steal u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .dest_field(dest_field),
    .refresh_req(refresh_req), .refresh_addr(refresh_addr), .addr_sel(addr_sel)
  );

  localparam int NV = 16;
  localparam logic [2:0] VEC [NV] = '{
    3'b101, 3'b110, 3'b000, 3'b101,
    3'b110, 3'b110, 3'b110, 3'b010, 3'b110, 3'b110,
    3'b110, 3'b110, 3'b110, 3'b110, 3'b001, 3'b000
  };

  function automatic logic [8:0] nxt(input logic [8:0] a);
    return {a[7:0], a[8] ^ a[4]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic msb);
    @(negedge clk);
    instr_valid = v;
    dest_field = {msb, 3'b101};
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    dest_field = 4'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_addr = 9'd1;
  endtask

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 req", refresh_req, 0);
    chk("R1 sel", addr_sel, 0);
    chk("R1 addr", refresh_addr, 9'd1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][2], VEC[i][1]);
      chk($sformatf("R2/R3/R7/R8 vec%0d req", i), refresh_req, VEC[i][0]);
      chk($sformatf("R2 vec%0d sel", i), addr_sel, VEC[i][0]);
      chk($sformatf("R4/R5 vec%0d addr", i), refresh_addr, model_addr);
      if (VEC[i][0]) model_addr = nxt(model_addr);
    end

    step(1'b0, 1'b0);
    chk("R8 idle after clear", refresh_req, 0);
    chk("R4 addr after table", refresh_addr, model_addr);

    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk("R8 eligible clears count", refresh_req, 1);
    model_addr = nxt(model_addr);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk("R8 count restarted, 7 below limit", refresh_req, 0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R7 forced on idle", refresh_req, 1);
    chk("R7 forced addr", refresh_addr, model_addr);

    do_reset();
    #1;
    chk("R1 addr after re-reset", refresh_addr, 9'd1);
    for (int i = 0; i < 512; i++) seen[i] = 1'b0;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 511; i++) begin
        step(1'b1, 1'b0);
        if (!refresh_req || refresh_addr == 9'd0 || seen[refresh_addr] || refresh_addr !== model_addr) bad++;
        seen[refresh_addr] = 1'b1;
        model_addr = nxt(model_addr);
      end
      chk("R6 distinct nonzero period", bad, 0);
    end
    step(1'b1, 1'b0);
    chk("R6 wrap to first", refresh_addr, 9'd1);
    step(1'b1, 1'b1);
    chk("R3 memory dest after run", refresh_req, 0);

    @(negedge clk);
    instr_valid = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule